// File: doc/BRIEF.md
# Timer Event Output Generator

This block drives one timer output pin from the event strobes of a counter that lives elsewhere. Each cycle it sees an overflow strobe, a compare-match strobe and a set of static control bits. From these it decides whether the pin shows a short pulse, flips its level, or rests at a programmed idle level. The control bits are a trigger-source select, a pulse-or-toggle select, the idle level, the pin direction and a running flag.

In toggle mode the overflow event and the match event each flip the pin. Together they form a simple PWM waveform: the pin flips at the compare point and again at the wrap point. In pulse mode every qualifying event sets the pin to the opposite of the idle level for exactly one cycle. When the pin is set as an input, the output register is frozen. The pin output is registered, so every decision shows on the pin one clock after the inputs that caused it.

All ports are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `tmr_evt_out`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `pin_out` is 0.
- R2: When `pin_dir_in` is 0 and `run` is 1, a `trig_mode` of 0 (no trigger) or 3 (reserved) sets `pin_out` to `idle_level` one cycle later, whatever the strobes are.
- R3: When `pin_dir_in` is 0 and `run` is 0, `pin_out` equals `idle_level` one cycle later, whatever the strobes and the mode are.
- R4: When `pin_dir_in` is 1, `pin_out` keeps its value one cycle later, whatever the other inputs are.
- R5: `ovf_evt` is a qualifying event when `trig_mode` is 1 or 2. `mat_evt` is a qualifying event only when `trig_mode` is 2. A match strobe with `trig_mode` 1 acts as no event.
- R6: In toggle mode (`toggle_sel` = 1), a cycle with at least one qualifying event inverts `pin_out` exactly once one cycle later. This holds even when both strobes are high together.
- R7: In toggle mode, a cycle with no qualifying event leaves `pin_out` unchanged one cycle later.
- R8: In pulse mode (`toggle_sel` = 0), a cycle with a qualifying event sets `pin_out` to the inverse of `idle_level` one cycle later. A cycle with no qualifying event sets it to `idle_level`. A single isolated event therefore gives a pulse exactly one cycle wide.
- R9: Rewriting the same `idle_level` while the pin already rests at that level leaves `pin_out` constant, with no glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt | input | 1 | One-cycle counter overflow strobe |
| mat_evt | input | 1 | One-cycle compare-match strobe |
| trig_mode | input | 2 | Trigger source select: 0 none, 1 overflow, 2 overflow and match, 3 reserved (treated as none) |
| toggle_sel | input | 1 | 1 = toggle on each event, 0 = one-cycle pulse on each event |
| idle_level | input | 1 | Level the pin rests at when inactive |
| pin_dir_in | input | 1 | 1 = pin is an input, so the output register is frozen |
| run | input | 1 | Counter running flag |
| pin_out | output | 1 | Registered pin level |

## Verification
The bound checker checks the following on every cycle:
- the output freezes while the pin is an input;
- the output falls back to the idle level when the counter is stopped or the mode is inactive;
- a toggle event inverts the output exactly once;
- a match strobe is ignored in overflow-only mode;
- a pulse event drives the inverse of the idle level.

Some behaviours show only over a sequence of cycles, so only the bench's scenarios can reveal them: a pulse that returns to idle, and a PWM waveform built from alternating events. The bench sweeps every input combination in several orders and compares each cycle against a model computed from the requirements. This covers each rule from both starting levels of the pin.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF     = 2'd0,
    TRIG_OVF     = 2'd1,
    TRIG_OVF_MAT = 2'd2,
    TRIG_RSVD    = 2'd3
  } trig_mode_e;

  // Only the two defined trigger sources make the block active.
  function automatic logic mode_active(input trig_mode_e m);
    return (m == TRIG_OVF) || (m == TRIG_OVF_MAT);
  endfunction
endpackage

// File: rtl/evt_trigger_sel.sv
module evt_trigger_sel
  import tmr_evt_pkg::*;
(
  input  logic       ovf_evt,
  input  logic       mat_evt,
  input  trig_mode_e mode,
  output logic       active,
  output logic       fire
);
  logic mat_ok;

  always_comb begin
    active = mode_active(mode);
    mat_ok = mat_evt && (mode == TRIG_OVF_MAT);
    // Both strobes together still count as a single event.
    fire   = active && (ovf_evt || mat_ok);
  end
endmodule

// File: rtl/evt_level_next.sv
module evt_level_next (
  input  logic cur_level,
  input  logic fire,
  input  logic active,
  input  logic run,
  input  logic toggle_sel,
  input  logic idle_level,
  input  logic pin_dir_in,
  output logic load,
  output logic nxt_level
);
  always_comb begin
    load      = 1'b0;
    nxt_level = cur_level;
    if (!pin_dir_in) begin
      if (!run || !active) begin
        nxt_level = idle_level;
      end else if (toggle_sel) begin
        nxt_level = fire ? ~cur_level : cur_level;
      end else begin
        nxt_level = fire ? ~idle_level : idle_level;
      end
      // Update only on a real level change.
      load = (nxt_level != cur_level);
    end
  end
endmodule

// File: rtl/tmr_evt_out.sv
module tmr_evt_out
  import tmr_evt_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ovf_evt,
  input  logic                mat_evt,
  input  logic [MODE_W-1:0]   trig_mode,
  input  logic                toggle_sel,
  input  logic                idle_level,
  input  logic                pin_dir_in,
  input  logic                run,
  output logic                pin_out
);
  trig_mode_e mode;
  logic       active;
  logic       fire;
  logic       load;
  logic       nxt_level;
  logic       level_q;

  assign mode = trig_mode_e'(trig_mode);

  evt_trigger_sel u_sel (
    .ovf_evt (ovf_evt),
    .mat_evt (mat_evt),
    .mode    (mode),
    .active  (active),
    .fire    (fire)
  );

  evt_level_next u_next (
    .cur_level  (level_q),
    .fire       (fire),
    .active     (active),
    .run        (run),
    .toggle_sel (toggle_sel),
    .idle_level (idle_level),
    .pin_dir_in (pin_dir_in),
    .load       (load),
    .nxt_level  (nxt_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= RESET_LEVEL;
    end else if (load) begin
      level_q <= nxt_level;
    end
  end

  assign pin_out = level_q;
endmodule

// File: rtl/tmr_evt_out_chk.sv
module tmr_evt_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovf_evt,
  input logic       mat_evt,
  input logic [1:0] trig_mode,
  input logic       toggle_sel,
  input logic       idle_level,
  input logic       pin_dir_in,
  input logic       run,
  input logic       pin_out
);
  logic drive_ok;
  logic act_mode;

  assign drive_ok = !pin_dir_in && run;
  assign act_mode = (trig_mode == 2'd1) || (trig_mode == 2'd2);

  AST_INPUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_dir_in |=> $stable(pin_out)); // R4

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_dir_in && !run) |=> (pin_out == $past(idle_level))); // R3

  AST_MODE_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && !act_mode) |=> (pin_out == $past(idle_level))); // R2

  AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && act_mode && toggle_sel && ovf_evt) |=> (pin_out != $past(pin_out))); // R6

  AST_MATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && trig_mode == 2'd1 && toggle_sel && mat_evt && !ovf_evt) |=> $stable(pin_out)); // R5

  AST_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && act_mode && !toggle_sel && ovf_evt) |=> (pin_out == !$past(idle_level))); // R8
endmodule

bind tmr_evt_out tmr_evt_out_chk u_chk (.*);

// File: tb/tb_tmr_evt_out.sv
module tb_tmr_evt_out;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ovf_evt, mat_evt;
  logic [1:0] trig_mode;
  logic       toggle_sel, idle_level, pin_dir_in, run;
  logic       pin_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic exp_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_out dut (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .mat_evt(mat_evt),
    .trig_mode(trig_mode), .toggle_sel(toggle_sel), .idle_level(idle_level),
    .pin_dir_in(pin_dir_in), .run(run), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin_out=%0b expected=%0b", req, act, exp);
    end
  endtask

  // combo bits: [0] ovf [1] mat [3:2] mode [4] toggle [5] idle [6] dir_in [7] run
  task automatic step(input logic [7:0] c);
    logic fire, exp;
    string req;
    @(negedge clk);
    ovf_evt = c[0]; mat_evt = c[1]; trig_mode = c[3:2];
    toggle_sel = c[4]; idle_level = c[5]; pin_dir_in = c[6]; run = c[7];
    fire = (c[3:2] == 2'd1 || c[3:2] == 2'd2) && (c[0] || (c[1] && c[3:2] == 2'd2));
    if (c[6]) begin
      exp = exp_q; req = "R4";
    end else if (!c[7]) begin
      exp = c[5]; req = "R3";
    end else if (c[3:2] == 2'd0 || c[3:2] == 2'd3) begin
      exp = c[5]; req = "R2";
    end else if (c[4]) begin
      exp = fire ? ~exp_q : exp_q;
      if (c[1] && !c[0]) req = "R5";
      else if (fire) req = "R6";
      else req = "R7";
    end else begin
      exp = fire ? ~c[5] : c[5];
      req = (c[1] && !c[0]) ? "R5" : "R8";
    end
    @(posedge clk);
    #1;
    check(req, pin_out, exp);
    exp_q = exp;
  endtask

  initial begin
    rst_n = 1'b0; ovf_evt = 0; mat_evt = 0; trig_mode = 2'd0;
    toggle_sel = 0; idle_level = 0; pin_dir_in = 0; run = 0;
    repeat (3) @(posedge clk);
    #1 check("R1", pin_out, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", pin_out, 1'b0);
    exp_q = 1'b0;

    // Four permutations of the full 256-combination sweep.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        int mult;
        mult = (p == 0) ? 1 : (p == 1) ? 5 : (p == 2) ? 77 : 151;
        step(8'((i * mult + p * 37) & 255));
      end
    end

    // R6 PWM: toggle on alternating match and overflow, mode 2.
    step(8'b1011_0000);
    for (int k = 0; k < 6; k++) begin
      step(8'b1001_1010);
      step(8'b1001_1000);
      step(8'b1001_1001);
    end
    // R8: isolated pulse with idle level 1, then return to idle.
    step(8'b1010_0100);
    step(8'b1010_0101);
    step(8'b1010_0100);
    // R9: same idle level rewritten, pin stays constant each cycle.
    for (int k = 0; k < 4; k++) begin
      step(8'b1010_0000);
      check("R9", pin_out, 1'b1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog pin_out=%0b expected=finish", pin_out);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule